// File: doc/BRIEF.md
# Memory Functional Test Pattern Engine

This block runs a self-contained functional test over a word-addressed memory through a plain request/ready port. After a start pulse it steps through four data backgrounds in a fixed order. For each background it first writes every word, then reads every word back and compares it with the value that background should leave there. Each mismatch is counted, and the first failing address is kept together with the word read from it. At the end the block gives a one-cycle done pulse and a pass flag that holds until the next start.

The checkerboard backgrounds follow the physical cell layout, not a constant word. The top `COL_BITS` address bits select the column inside each group, and the remaining low bits select the row. Bit `j` of a word comes from the sense group `j`, whose physical column is `j*GRP_COLS + colsel`. A cell holds one in the checkerboard when the parity of its row, taken from its lowest bit, differs from the parity of its physical column. The memory may take any number of cycles to accept each access, so the block suits arrays whose write and read times vary. The word width is a parameter and covers both 16-bit and 8-bit organisations.

Controller states are `ST_IDLE`, `ST_WRITE`, `ST_READ`, `ST_NEXT` and `ST_DONE`. The transitions are:
- `ST_IDLE` to `ST_WRITE` on start.
- `ST_WRITE` to `ST_READ` when the last word is accepted.
- `ST_READ` to `ST_NEXT` when the last word is read.
- `ST_NEXT` to `ST_WRITE` while backgrounds remain, or to `ST_DONE` after the inverted checkerboard.
- `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `mbist_engine`

## Requirements
- R1: A start pulse is accepted only in `ST_IDLE`. Accepting it clears the error count, the first-fail record and the pass flag. A start seen while a test runs has no effect on the access sequence or on the number of done pulses.
- R2: Backgrounds run in the order zeros, all ones, checkerboard, inverted checkerboard. The checkerboard word at address `a` has bit `j` equal to `a[0] ^ a[ADDR_W-COL_BITS] ^ ((j*GRP_COLS) mod 2)`. With the default even `GRP_COLS`, the word is all ones when `a[0] ^ a[ADDR_W-COL_BITS]` is 1 and all zeros otherwise. The inverted checkerboard is its bitwise complement.
- R3: Each background is one write pass over addresses 0 to 2^ADDR_W-1 in ascending order, followed by one read pass in the same order.
- R4: An access is presented with `mem_req_o` high and completes in the cycle that `mem_ready_i` is high. Until then the address, write enable and write data stay stable. Read data is taken in the completing cycle.
- R5: Each read whose data differs from the expected word adds one to the error count. The count saturates at 2^ERR_W-1.
- R6: The address and read data of the first mismatch after a start are latched and held.
- R7: After the last read of the inverted checkerboard, `done_o` is high for exactly one cycle. From the next cycle `pass_o` is 1 if the error count is zero and 0 otherwise.
- R8: The block operates with word widths of 16 and 8 bits.
- R9: After reset there is no memory request, `done_o` and `pass_o` are 0, and the error count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a test run |
| done_o | output | 1 | One-cycle pulse at end of run |
| pass_o | output | 1 | Run finished with no mismatch |
| err_cnt_o | output | ERR_W | Saturating mismatch count |
| fail_addr_o | output | ADDR_W | Address of first mismatch |
| fail_data_o | output | DATA_W | Data read at first mismatch |
| mem_req_o | output | 1 | Access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with ready on reads |
| mem_ready_i | input | 1 | Memory accepts the access this cycle |

## Verification
The assertions assume that the memory never raises `mem_ready_i` without a pending request that it will accept. They also assume that read data is settled in the cycle ready is high. The bench memory model asserts ready only as a function of the live request and a wait counter, and it computes read data from its storage in that same cycle. The model adds a configurable wait of zero to three cycles and an optional fault overlay. Start pulses, both the accepted ones and the stray one sent mid-run, are driven on the falling edge, away from the sampling edge.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_NEXT,
        ST_DONE
    } mbist_state_e;

    typedef enum logic [1:0] {
        PAT_ZEROS,
        PAT_ONES,
        PAT_CHECK,
        PAT_CHECK_INV
    } mbist_pat_e;
endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (clr)
            addr <= '0;
        else if (step)
            addr <= addr + ADDR_W'(1);
    end

    assign last = (addr == TOP);
endmodule

// File: rtl/mbist_pattern_gen.sv
module mbist_pattern_gen
    import mbist_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int COL_BITS = 4,
    parameter int GRP_COLS = 16
) (
    input  mbist_pat_e        pat,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int ROW_W = ADDR_W - COL_BITS;

    logic base_par;
    assign base_par = addr[0] ^ addr[ROW_W];

    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        localparam bit COL_PAR = ((j * GRP_COLS) % 2) == 1;
        logic cb;
        assign cb = base_par ^ COL_PAR;
        assign data[j] = (pat == PAT_ONES)
                       | ((pat == PAT_CHECK) & cb)
                       | ((pat == PAT_CHECK_INV) & ~cb);
    end
endmodule

// File: rtl/mbist_err_log.sv
module mbist_err_log #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rdata,
    output logic [ERR_W-1:0]  err_cnt,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_data
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt   <= '0;
            seen      <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
        end else if (clr) begin
            err_cnt   <= '0;
            seen      <= 1'b0;
            fail_addr <= '0;
            fail_data <= '0;
        end else if (hit) begin
            if (err_cnt != CNT_MAX)
                err_cnt <= err_cnt + ERR_W'(1);
            if (!seen) begin
                seen      <= 1'b1;
                fail_addr <= addr;
                fail_data <= rdata;
            end
        end
    end
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int COL_BITS = 4,
    parameter int GRP_COLS = 16,
    parameter int ERR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              done_o,
    output logic              pass_o,
    output logic [ERR_W-1:0]  err_cnt_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_data_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i
);
    mbist_state_e      state, state_n;
    mbist_pat_e        pat;
    logic              start_acc, acc_ok, addr_last, mismatch;
    logic [DATA_W-1:0] exp_data;

    assign start_acc = start_i && (state == ST_IDLE);
    assign acc_ok    = mem_req_o && mem_ready_i;
    assign mismatch  = (state == ST_READ) && acc_ok && (mem_rdata_i != exp_data);

    mbist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start_acc || (acc_ok && addr_last)),
        .step (acc_ok && !addr_last),
        .addr (mem_addr_o),
        .last (addr_last)
    );

    mbist_pattern_gen #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .COL_BITS(COL_BITS),
        .GRP_COLS(GRP_COLS)
    ) u_pat (
        .pat (pat),
        .addr(mem_addr_o),
        .data(exp_data)
    );

    mbist_err_log #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .ERR_W (ERR_W)
    ) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_acc),
        .hit      (mismatch),
        .addr     (mem_addr_o),
        .rdata    (mem_rdata_i),
        .err_cnt  (err_cnt_o),
        .fail_addr(fail_addr_o),
        .fail_data(fail_data_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (start_i) state_n = ST_WRITE;
            ST_WRITE: if (acc_ok && addr_last) state_n = ST_READ;
            ST_READ:  if (acc_ok && addr_last) state_n = ST_NEXT;
            ST_NEXT:  state_n = (pat == PAT_CHECK_INV) ? ST_DONE : ST_WRITE;
            ST_DONE:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // background selector and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat    <= PAT_ZEROS;
            pass_o <= 1'b0;
        end else begin
            if (start_acc) begin
                pat    <= PAT_ZEROS;
                pass_o <= 1'b0;
            end else if (state == ST_NEXT && pat != PAT_CHECK_INV) begin
                pat <= mbist_pat_e'(pat + 2'd1);
            end
            if (state == ST_DONE)
                pass_o <= (err_cnt_o == '0);
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_req_o = 1'b0;
        mem_we_o  = 1'b0;
        done_o    = 1'b0;
        unique case (state)
            ST_WRITE: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
            ST_READ:  mem_req_o = 1'b1;
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
    end

    assign mem_wdata_o = exp_data;
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int ERR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              done_o,
    input logic              pass_o,
    input logic [ERR_W-1:0]  err_cnt_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input mbist_state_e      state
);
    localparam logic [ERR_W-1:0]  CNT_MAX  = '1;
    localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && mem_addr_o != ADDR_TOP)
            |=> (mem_req_o && mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state == ST_IDLE) |=> (state == ST_WRITE && err_cnt_o == '0 && !pass_o));

    p_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt_o == CNT_MAX && !(start_i && state == ST_IDLE)) |=> err_cnt_o == CNT_MAX);

    p_err_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && state == ST_IDLE) |=> err_cnt_o >= $past(err_cnt_o));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (pass_o == (err_cnt_o == '0)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_req_o && !done_o));
endmodule

bind mbist_engine mbist_engine_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ERR_W (ERR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .err_cnt_o  (err_cnt_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i),
    .state      (state)
);

// File: tb/tb_mbist_engine.sv
`timescale 1ns/1ps

module tb_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int COL_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    input  logic [1:0]        lat,
    input  logic              flt_en,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [DATA_W-1:0] flt_or,
    input  logic              xor_all,
    input  logic              seq_clr,
    output int                seq_err
);
    localparam int N = 2 ** ADDR_W;
    logic [DATA_W-1:0] mem [N];
    logic [1:0] lat_cnt;
    int idx;

    function automatic logic [DATA_W-1:0] expw(int p, int a);
        logic b;
        b = ((a & 1) != 0) ^ (((a >> (ADDR_W - COL_BITS)) & 1) != 0);
        case (p)
            0: return '0;
            1: return '1;
            2: return b ? '1 : '0;
            default: return b ? '0 : '1;
        endcase
    endfunction

    assign ready = req && (lat_cnt == lat);

    always_comb begin
        rdata = mem[addr];
        if (flt_en && addr == flt_addr) rdata = rdata | flt_or;
        if (xor_all) rdata = ~rdata;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            idx     <= 0;
            seq_err <= 0;
        end else begin
            if (req && !ready) lat_cnt <= lat_cnt + 2'd1;
            else lat_cnt <= '0;
            if (seq_clr) begin
                idx     <= 0;
                seq_err <= 0;
            end else if (req && ready) begin
                if (we) mem[addr] <= wdata;
                if (idx / (2 * N) > 3 || we !== ((idx % (2 * N)) < N) ||
                    int'(addr) != (idx % N) ||
                    (we && wdata !== expw(idx / (2 * N), idx % N)))
                    seq_err <= seq_err + 1;
                idx <= idx + 1;
            end
        end
    end
endmodule

module tb_mbist_engine;
    localparam int AW = 6;
    localparam int EW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // wide instance signals
    logic start16 = 1'b0, done16, pass16, req16, we16, rdy16;
    logic [EW-1:0] err16;
    logic [AW-1:0] fa16, addr16;
    logic [15:0] fd16, wd16, rd16;
    // narrow instance signals
    logic start8 = 1'b0, done8, pass8, req8, we8, rdy8;
    logic [EW-1:0] err8;
    logic [AW-1:0] fa8, addr8;
    logic [7:0] fd8, wd8, rd8;

    logic [1:0] lat = 2'd0;
    logic flt_en = 1'b0, xor_all = 1'b0, seq_clr = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    logic [15:0] flt_or16 = '0;
    logic [7:0] flt_or8 = '0;
    int seq16, seq8;

    mbist_engine #(.ADDR_W(AW), .DATA_W(16), .ERR_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start16), .done_o(done16),
        .pass_o(pass16), .err_cnt_o(err16), .fail_addr_o(fa16),
        .fail_data_o(fd16), .mem_req_o(req16), .mem_we_o(we16),
        .mem_addr_o(addr16), .mem_wdata_o(wd16), .mem_rdata_i(rd16),
        .mem_ready_i(rdy16));

    mbist_engine #(.ADDR_W(AW), .DATA_W(8), .ERR_W(EW)) dut_nar (
        .clk(clk), .rst_n(rst_n), .start_i(start8), .done_o(done8),
        .pass_o(pass8), .err_cnt_o(err8), .fail_addr_o(fa8),
        .fail_data_o(fd8), .mem_req_o(req8), .mem_we_o(we8),
        .mem_addr_o(addr8), .mem_wdata_o(wd8), .mem_rdata_i(rd8),
        .mem_ready_i(rdy8));

    tb_mem #(.ADDR_W(AW), .DATA_W(16)) u_mem16 (
        .clk(clk), .rst_n(rst_n), .req(req16), .we(we16), .addr(addr16),
        .wdata(wd16), .rdata(rd16), .ready(rdy16), .lat(lat),
        .flt_en(flt_en), .flt_addr(flt_addr), .flt_or(flt_or16),
        .xor_all(xor_all), .seq_clr(seq_clr), .seq_err(seq16));

    tb_mem #(.ADDR_W(AW), .DATA_W(8)) u_mem8 (
        .clk(clk), .rst_n(rst_n), .req(req8), .we(we8), .addr(addr8),
        .wdata(wd8), .rdata(rd8), .ready(rdy8), .lat(lat),
        .flt_en(flt_en), .flt_addr(flt_addr), .flt_or(flt_or8),
        .xor_all(xor_all), .seq_clr(seq_clr), .seq_err(seq8));

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // start one run; optional stray start at cycle mid; returns done pulse count
    task automatic run_engine(input bit nar, input int mid, output int dn);
        bit d;
        dn = 0;
        @(negedge clk); seq_clr = 1'b1;
        @(negedge clk); seq_clr = 1'b0;
        if (nar) start8 = 1'b1; else start16 = 1'b1;
        @(negedge clk); start8 = 1'b0; start16 = 1'b0;
        for (int k = 1; k < 20000; k++) begin
            @(negedge clk);
            if (nar) start8 = (mid != 0 && k == mid);
            else start16 = (mid != 0 && k == mid);
            d = nar ? done8 : done16;
            if (d) dn++;
            if (dn > 0 && !d) break;
        end
        start8 = 1'b0; start16 = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 req16 at reset", req16, 0);
        check("R9 done16 at reset", done16, 0);
        check("R9 pass16 at reset", pass16, 0);
        check("R9 err16 at reset", err16, 0);
        check("R9 req8 at reset", req8, 0);
        check("R9 err8 at reset", err8, 0);
    endtask

    task automatic t_clean(input logic [1:0] l);
        int dn;
        lat = l;
        run_engine(1'b0, 0, dn);
        check("R7 single done pulse", dn, 1);
        check("R7 pass on clean run", pass16, 1);
        check("R5 no errors on clean run", err16, 0);
        check("R2 R3 R4 access order and data", seq16, 0);
    endtask

    task automatic t_stuck_bit();
        int dn;
        lat = 2'd1;
        flt_en = 1'b1; flt_addr = AW'(20); flt_or16 = 16'h0001;
        run_engine(1'b0, 0, dn);
        // addr 20: checkerboard word all ones, so bit0 stuck high fails zeros and inverse
        check("R5 stuck bit count", err16, 2);
        check("R6 first fail addr", fa16, 20);
        check("R6 first fail data", fd16, 16'h0001);
        check("R7 pass low on failure", pass16, 0);
        flt_en = 1'b0; flt_or16 = '0;
    endtask

    task automatic t_saturate();
        int dn;
        lat = 2'd0;
        xor_all = 1'b1;
        run_engine(1'b0, 0, dn);
        check("R5 saturated count", err16, 255);
        check("R6 first fail at address 0", fa16, 0);
        check("R6 first fail data inverted zeros", fd16, 16'hFFFF);
        xor_all = 1'b0;
    endtask

    task automatic t_restart_clears();
        int dn;
        lat = 2'd2;
        run_engine(1'b0, 0, dn);
        check("R1 restart clears count", err16, 0);
        check("R1 restart clears fail addr", fa16, 0);
        check("R1 pass after restart", pass16, 1);
    endtask

    task automatic t_stray_start();
        int dn;
        lat = 2'd1;
        run_engine(1'b0, 150, dn);
        check("R1 stray start single done", dn, 1);
        check("R1 stray start sequence unchanged", seq16, 0);
        check("R1 stray start pass", pass16, 1);
    endtask

    task automatic t_narrow();
        int dn;
        lat = 2'd3;
        run_engine(1'b1, 0, dn);
        check("R8 narrow done", dn, 1);
        check("R8 narrow pass", pass8, 1);
        check("R8 narrow sequence", seq8, 0);
        flt_en = 1'b1; flt_addr = AW'(20); flt_or8 = 8'h80;
        run_engine(1'b1, 0, dn);
        check("R8 narrow stuck count", err8, 2);
        check("R8 narrow fail data", fd8, 8'h80);
        check("R8 narrow pass low", pass8, 0);
        flt_en = 1'b0; flt_or8 = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean(2'd0);
        t_clean(2'd3);
        t_stuck_bit();
        t_saturate();
        t_restart_clears();
        t_stray_start();
        t_narrow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule